// File: doc/BRIEF.md
# Watchdog Timer with Reset Pulse

This block is a software-serviced watchdog. An 8-bit count register is loaded through a small synchronous register port. While the timer is enabled and the count is nonzero, the count steps down by one each time a prescaler completes one period of the selected time unit. The unit is 1 s, 100 ms, 10 ms or 1 ms, and the cycle counts come from a clock-frequency parameter. Software reads the count register at any time to see how many units remain. It reloads the register to keep the timer from expiring.

When the count steps from 1 to 0, the timer has expired. The block then sets a sticky expiry flag in the control register and drives an active-low reset output. The width of that pulse is chosen from the same four units, independently of the tick unit. A pulse already in progress is never stretched by a later expiry. The power-on reset clears every register and releases the reset output.

Top module: `wdt_pulse_reset`

## Requirements
- R1: After power-on reset both registers read 00h and `rst_out_n` is high.
- R2: A write to address 0 loads the count. A read of address 0 returns the live remaining count.
- R3: With the enable bit set and the count nonzero, the count drops by exactly one every U clock cycles. U is CLK_HZ for unit code 00, CLK_HZ/10 for 01, CLK_HZ/100 for 10 and CLK_HZ/1000 for 11. With the enable bit clear, the count holds.
- R4: Every write to the count restarts the prescaler. The first decrement after such a write comes a full U cycles after the write edge.
- R5: On the step from 1 to 0, control bit 7 becomes 1 and stays 1. A control write with bit 7 at 0 clears it. A control write with bit 7 at 1 leaves it unchanged.
- R6: `rst_out_n` goes low on the clock edge where the count reaches 0. It stays low for exactly P cycles, where P uses the unit coding of R3 applied to the pulse-width field.
- R7: An expiry that occurs while the pulse is active neither restarts nor lengthens it.
- R8: At address 1, bit 6 is the enable, bits 3:2 are the tick unit and bits 1:0 are the pulse-width unit. Bits 5:4 read as 0. All three fields read back as written.
- R9: A count of 0 with the timer enabled never expires and never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ hertz |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_addr | input | 1 | Register select: 0 = count, 1 = control/status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| rst_out_n | output | 1 | Active-low reset pulse issued on expiry |

## Verification
Some properties hold on every cycle and are checked by the assertions. The count only ever holds or steps down by one unless software writes it, and it is frozen while disabled. The expiry flag never drops without a clearing write. A zero count never produces a tick. Every falling edge of the reset output follows an expiry. The exact tick spacing for each unit, the restart of the prescaler on a reload, the exact pulse width for each unit and the refusal to retrigger a running pulse depend on cycle counts. Only the bench's timed scenarios show those.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        UNIT_1S    = 2'b00,
        UNIT_100MS = 2'b01,
        UNIT_10MS  = 2'b10,
        UNIT_1MS   = 2'b11
    } unit_e;

    localparam logic ADDR_COUNT = 1'b0;
    localparam logic ADDR_CTRL  = 1'b1;

    localparam int BIT_EXPIRED = 7;
    localparam int BIT_ENABLE  = 6;

    typedef struct packed {
        logic [7:0] count;
        logic       expired;
        logic       enable;
        unit_e      tick_unit;
        unit_e      pulse_unit;
    } wdt_regs_t;

    // Clock cycles in one time unit for a clock of hz hertz.
    function automatic int unsigned unit_cycles(input int unsigned hz, input unit_e u);
        case (u)
            UNIT_1S:    return hz;
            UNIT_100MS: return hz / 10;
            UNIT_10MS:  return hz / 100;
            default:    return hz / 1000;
        endcase
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic  clk,
    input  logic  por_n,
    input  logic  restart,
    input  logic  run,
    input  unit_e unit,
    output logic  tick
);
    localparam int unsigned DIV_W = $clog2(CLK_HZ);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = DIV_W'(unit_cycles(CLK_HZ, unit) - 1);
        // >= covers a unit change to a shorter period mid-count
        tick  = run && !restart && (cnt_q >= lim);
        cnt_d = cnt_q + 1'b1;
        if (restart || !run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic  clk,
    input  logic  por_n,
    input  logic  fire,
    input  unit_e unit,
    output logic  active
);
    localparam int unsigned DIV_W = $clog2(CLK_HZ);

    typedef struct packed {
        logic             active;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] lim;
    } pulse_t;

    pulse_t d, q;
    logic   last;

    always_comb begin
        d    = q;
        last = q.active && (q.cnt >= q.lim);
        if (q.active) begin
            if (last) begin
                d.active = 1'b0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        // accepted only when idle or in the final cycle: no stretching
        if (fire && (!q.active || last)) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.lim    = DIV_W'(unit_cycles(CLK_HZ, unit) - 1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active = q.active;

endmodule

// File: rtl/wdt_pulse_reset.sv
module wdt_pulse_reset
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       rst_out_n
);
    wdt_regs_t r_d, r_q;

    logic       wr_count, wr_ctrl;
    logic       run, tick, timeout, pulse_active;
    logic [7:0] count_q;
    logic       expired_q, enable_q;
    logic       unused_wdata;

    assign unused_wdata = ^reg_wdata[5:4];

    assign wr_count  = reg_wr && (reg_addr == ADDR_COUNT);
    assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
    assign run       = r_q.enable && (r_q.count != 8'd0);
    assign timeout   = tick && (r_q.count == 8'd1);
    assign count_q   = r_q.count;
    assign expired_q = r_q.expired;
    assign enable_q  = r_q.enable;

    wdt_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
        .clk     (clk),
        .por_n   (por_n),
        .restart (wr_count),
        .run     (run),
        .unit    (r_q.tick_unit),
        .tick    (tick)
    );

    wdt_pulse_gen #(.CLK_HZ(CLK_HZ)) u_pulse (
        .clk    (clk),
        .por_n  (por_n),
        .fire   (timeout),
        .unit   (r_q.pulse_unit),
        .active (pulse_active)
    );

    always_comb begin
        r_d = r_q;
        if (tick) begin
            r_d.count = r_q.count - 8'd1;
        end
        if (wr_count) begin
            r_d.count = reg_wdata;
        end
        if (wr_ctrl) begin
            r_d.enable     = reg_wdata[BIT_ENABLE];
            r_d.tick_unit  = unit_e'(reg_wdata[3:2]);
            r_d.pulse_unit = unit_e'(reg_wdata[1:0]);
            if (!reg_wdata[BIT_EXPIRED]) begin
                r_d.expired = 1'b0;
            end
        end
        // a fresh expiry wins over a same-cycle clear
        if (timeout) begin
            r_d.expired = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (reg_addr == ADDR_COUNT) begin
            reg_rdata = r_q.count;
        end else begin
            reg_rdata = {r_q.expired, r_q.enable, 2'b00, r_q.tick_unit, r_q.pulse_unit};
        end
    end

    assign rst_out_n = !pulse_active;

endmodule

// File: rtl/wdt_pulse_reset_chk.sv
module wdt_pulse_reset_chk (
    input logic       clk,
    input logic       por_n,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic       rst_out_n,
    input logic [7:0] count_q,
    input logic       expired_q,
    input logic       enable_q,
    input logic       tick
);
    logic count_wr, clear_wr;
    assign count_wr = reg_wr && (reg_addr == 1'b0);
    assign clear_wr = reg_wr && (reg_addr == 1'b1) && !reg_wdata[7];

    p_count_step_r3: assert property (@(posedge clk) disable iff (!por_n)
        !count_wr |=> (count_q == $past(count_q)) || (count_q == $past(count_q) - 8'd1));

    p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!por_n)
        (!enable_q && !count_wr) |=> $stable(count_q));

    p_expired_sticky_r5: assert property (@(posedge clk) disable iff (!por_n)
        (expired_q && !clear_wr) |=> expired_q);

    p_expiry_sets_flag_r5: assert property (@(posedge clk) disable iff (!por_n)
        (tick && count_q == 8'd1) |=> (expired_q && !rst_out_n));

    p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_out_n) |-> $past(tick && count_q == 8'd1));

    p_zero_no_tick_r9: assert property (@(posedge clk) disable iff (!por_n)
        (count_q == 8'd0) |-> !tick);

endmodule

bind wdt_pulse_reset wdt_pulse_reset_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rst_out_n (rst_out_n),
    .count_q   (count_q),
    .expired_q (expired_q),
    .enable_q  (enable_q),
    .tick      (tick)
);

// File: tb/wdt_pulse_reset_tb.sv
module wdt_pulse_reset_tb;
    localparam int unsigned HZ = 10_000;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rst_out_n;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdt_pulse_reset #(.CLK_HZ(HZ)) u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rst_out_n (rst_out_n)
    );

    typedef struct packed {
        logic [1:0] tu;
        logic [1:0] pu;
        logic [7:0] n;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd3, 2'd3, 8'd3},
        '{2'd2, 2'd3, 8'd2},
        '{2'd3, 2'd2, 8'd1},
        '{2'd1, 2'd1, 8'd1},
        '{2'd0, 2'd3, 8'd1},
        '{2'd3, 2'd0, 8'd1}
    };

    function automatic int cyc(input logic [1:0] u);
        case (u)
            2'd0:    return 10000;
            2'd1:    return 1000;
            2'd2:    return 100;
            default: return 10;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); chk("R1 count", v, 8'h00);
        rd(1'b1, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 rst_out_n", rst_out_n, 1'b1);

        // Table walk: R2 R3 R5 R6 R8
        for (int i = 0; i < 6; i++) begin
            int tot;
            int pw;
            tot = int'(VECS[i].n) * cyc(VECS[i].tu);
            pw  = cyc(VECS[i].pu);
            wr(1'b1, {2'b01, 2'b00, VECS[i].tu, VECS[i].pu});
            rd(1'b1, v); chk("R8 ctrl readback", v, {2'b01, 2'b00, VECS[i].tu, VECS[i].pu});
            wr(1'b0, VECS[i].n);
            rd(1'b0, v); chk("R2 count load", v, VECS[i].n);
            repeat (tot - 1) @(negedge clk);
            rd(1'b0, v); chk("R3 one unit before expiry", v, 8'd1);
            chk("R6 high before expiry", rst_out_n, 1'b1);
            @(negedge clk);
            rd(1'b0, v); chk("R3 expired count", v, 8'd0);
            rd(1'b1, v); chk("R5 flag set", v[7], 1'b1);
            chk("R6 pulse start", rst_out_n, 1'b0);
            repeat (pw - 1) @(negedge clk);
            chk("R6 pulse still low", rst_out_n, 1'b0);
            @(negedge clk);
            chk("R6 pulse end", rst_out_n, 1'b1);
            wr(1'b1, 8'h00);
            rd(1'b1, v); chk("R5 flag cleared", v[7], 1'b0);
        end

        // R3 hold while disabled
        wr(1'b1, 8'h0F);
        wr(1'b0, 8'd5);
        repeat (50) @(negedge clk);
        rd(1'b0, v); chk("R3 disabled hold", v, 8'd5);

        // R9 zero count with enable
        wr(1'b1, 8'h4F);
        wr(1'b0, 8'd0);
        repeat (50) @(negedge clk);
        rd(1'b0, v); chk("R9 zero stays", v, 8'd0);
        rd(1'b1, v); chk("R9 no flag", v[7], 1'b0);
        chk("R9 no pulse", rst_out_n, 1'b1);

        // R4 prescaler restart on reload (1 ms unit = 10 cycles)
        wr(1'b0, 8'd3);
        repeat (4) @(negedge clk);
        wr(1'b0, 8'd2);
        repeat (9) @(negedge clk);
        rd(1'b0, v); chk("R4 no early tick", v, 8'd2);
        @(negedge clk);
        rd(1'b0, v); chk("R4 full unit tick", v, 8'd1);
        repeat (10) @(negedge clk);
        rd(1'b0, v); chk("R4 expiry", v, 8'd0);
        chk("R4 pulse", rst_out_n, 1'b0);
        repeat (12) @(negedge clk);
        wr(1'b1, 8'h4F);

        // R7 no retrigger: tick 1 ms, pulse 100 ms (1000 cycles)
        wr(1'b1, 8'h4D);
        wr(1'b0, 8'd1);
        repeat (10) @(negedge clk);
        chk("R7 first pulse", rst_out_n, 1'b0);
        wr(1'b0, 8'd1);
        repeat (10) @(negedge clk);
        rd(1'b0, v); chk("R7 second expiry", v, 8'd0);
        chk("R7 still low", rst_out_n, 1'b0);
        repeat (987) @(negedge clk);
        chk("R7 low to original end", rst_out_n, 1'b0);
        @(negedge clk);
        chk("R7 not stretched", rst_out_n, 1'b1);

        // R5 writing 1 to the flag keeps it, writing 0 clears it
        wr(1'b1, 8'h80);
        rd(1'b1, v); chk("R5 write one keeps", v[7], 1'b1);
        rd(1'b1, v); chk("R8 reserved zero", v[5:4], 2'b00);
        wr(1'b1, 8'h00);
        rd(1'b1, v); chk("R5 write zero clears", v[7], 1'b0);

        finish_run();
    end

endmodule